// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Microprocessor Bus

This block is the digital core of an 8-bit successive-approximation converter. The comparator, DAC and analog front end sit outside it. The block presents a trial code to the DAC and reads back a one-bit comparator decision, which is high when the analog input is at or above the trial level. From these it runs a binary search that starts at the most significant bit. A one-hot step register advances the search on an internal tick at one eighth of the external clock rate. When the last bit has been decided, the finished code is copied into a result latch and an active-low interrupt is raised.

A host controls the block with active-low select, read and write strobes, all sampled on the external clock. A write with select low arms a start flip-flop. Arming aborts any search in progress, and the new search begins on the first internal tick after the write strobe returns high. A read with select low clears the interrupt and turns on the data pad driver. The pad cell itself is outside the block, so the bus is exposed as a data output plus an enable.

The interrupt set request stays active for a fixed number of external clocks, and a set overrides a clear. As a result, a host that keeps select and read low still sees a full-length interrupt pulse at every completion. Free-running operation is obtained by feeding the interrupt back into the write strobe with select held low. In that mode, arming kills the set request, so the interrupt gives only a two-cycle pulse before the next search starts.

Top module: `sar_bus_ctrl`

## Requirements
- R1: A synchronous reset leaves intr_n high, data_oe low, trial_code at 0, and the result latch at 0, so the first read returns 0.
- R2: data_oe is high only while cs_n and rd_n are both low. Whenever data_oe is low, data_out is 0.
- R3: The comparator input cmp_ge is 1 when the analog level is at or above trial_code. Under that convention, a completed search latches exactly the input level's code, for every code from 0 to 255. The latch changes only when a search completes.
- R4: The search runs MSB first. The first nonzero trial_code after a start is 0x80, and exactly one step bit is active while a search runs.
- R5: intr_n falls between 8*8+1 = 65 and (8+1)*8 = 72 clock cycles after the first clock edge that samples wr_n high following the arming write.
- R6: Once the set request has expired, a clock edge with cs_n and rd_n low returns intr_n high. Until then, intr_n stays low with no read.
- R7: The set request lasts 8 external clocks and overrides a read. With cs_n and rd_n held low throughout, intr_n is low for exactly 8 cycles at each completion.
- R8: A write during a search aborts it and restarts from the MSB. The latch keeps the previous result until the new search completes.
- R9: Arming (cs_n and wr_n low) clears a pending interrupt within two clock edges.
- R10: With intr_n looped to wr_n and cs_n held low, conversions repeat back to back. Each intr_n low pulse lasts 1 to 2 cycles, and each result matches its input.
- R11: Write strobes while cs_n is high start nothing: intr_n stays high and the latch is unchanged.
- R12: A reset during a search abandons it. Afterwards intr_n is high, trial_code is 0, a read returns 0, and the next search works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write/start strobe, active low; the start takes effect after it rises |
| cmp_ge | input | 1 | Comparator decision: 1 when the input is at or above trial_code |
| trial_code | output | 8 | Code presented to the DAC |
| intr_n | output | 1 | End-of-conversion interrupt, active low |
| data_out | output | 8 | Result latch value toward the pad cell, 0 when not enabled |
| data_oe | output | 1 | Pad driver enable for the data bus |

## Verification
Any wrong bit decision in the search shows up at the next completed read as a code different from the input level. Because every code is swept, each bit position is exercised in both directions. A step register that slips, or a mistimed tick, moves the interrupt outside its 65 to 72 cycle window or breaks the 0x80 first-trial check right after launch. Faults in the interrupt flip-flop's set and clear priority appear within one conversion: as a wrong pulse width under a continuous read, as a pulse longer than two cycles in free-running mode, or as an interrupt that a read or an arming write fails to clear within two edges.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // One search step: keep or drop the bit under trial, then place the next trial bit.
  // When the step mask is the LSB, the shifted mask is zero and the value is final.
  function automatic logic [31:0] sar_next(input logic [31:0] code,
                                           input logic [31:0] step_mask,
                                           input logic        keep);
    logic [31:0] decided;
    decided  = keep ? code : (code & ~step_mask);
    sar_next = decided | (step_mask >> 1);
  endfunction

endpackage

// File: rtl/sar_prescale.sv
module sar_prescale #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/sar_search.sv
module sar_search #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         launch,
  input  logic         hold,
  input  logic         cmp_ge,
  output logic [W-1:0] trial,
  output logic [W-1:0] ring,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] final_code
);

  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sar_q;
  logic [W-1:0] ring_q;
  logic         busy_q;
  logic [W-1:0] step_val;

  assign step_val = W'(sar_pkg::sar_next(32'(sar_q), 32'(ring_q), cmp_ge));

  always_ff @(posedge clk) begin
    if (rst) begin
      sar_q  <= '0;
      ring_q <= '0;
      busy_q <= 1'b0;
    end else if (launch) begin
      sar_q  <= MSB;
      ring_q <= MSB;
      busy_q <= 1'b1;
    end else if (hold) begin
      sar_q  <= '0;
      ring_q <= '0;
      busy_q <= 1'b0;
    end else if (tick && busy_q) begin
      sar_q  <= step_val;
      ring_q <= ring_q >> 1;
      busy_q <= !ring_q[0];
    end
  end

  assign trial      = sar_q;
  assign ring       = ring_q;
  assign busy       = busy_q;
  assign done       = tick && busy_q && ring_q[0] && !hold;
  assign final_code = step_val;

endmodule

// File: rtl/sar_irq.sv
module sar_irq #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic kill,
  input  logic clear,
  output logic intr_n,
  output logic set_active
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD - 1);

  logic [CW-1:0] set_cnt_q;
  logic          intr_q;

  always_ff @(posedge clk) begin
    if (rst)                  set_cnt_q <= '0;
    else if (kill)            set_cnt_q <= '0;
    else if (done)            set_cnt_q <= RELOAD;
    else if (set_cnt_q != '0) set_cnt_q <= set_cnt_q - 1'b1;
  end

  assign set_active = (set_cnt_q != '0);

  // set dominates clear
  always_ff @(posedge clk) begin
    if (rst)                     intr_q <= 1'b0;
    else if (done || set_active) intr_q <= 1'b1;
    else if (clear)              intr_q <= 1'b0;
  end

  assign intr_n = !intr_q;

endmodule

// File: rtl/sar_bus_ctrl.sv
module sar_bus_ctrl #(
  parameter int W        = 8,
  parameter int DIV      = 8,
  parameter int SET_HOLD = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         cmp_ge,
  output logic [W-1:0] trial_code,
  output logic         intr_n,
  output logic [W-1:0] data_out,
  output logic         data_oe
);

  // named internal events, also observed by the bound checker
  logic         tick;
  logic         arm;
  logic         launch;
  logic         start_ff;
  logic         rd_sel;
  logic         busy;
  logic         done;
  logic         set_active;
  logic [W-1:0] ring;
  logic [W-1:0] final_code;
  logic [W-1:0] result_q;

  assign arm    = !cs_n && !wr_n;
  assign rd_sel = !cs_n && !rd_n;
  assign launch = tick && start_ff && wr_n;

  always_ff @(posedge clk) begin
    if (rst)         start_ff <= 1'b0;
    else if (arm)    start_ff <= 1'b1;
    else if (launch) start_ff <= 1'b0;
  end

  sar_prescale #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  sar_search #(.W(W)) u_search (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .launch     (launch),
    .hold       (start_ff),
    .cmp_ge     (cmp_ge),
    .trial      (trial_code),
    .ring       (ring),
    .busy       (busy),
    .done       (done),
    .final_code (final_code)
  );

  always_ff @(posedge clk) begin
    if (rst)       result_q <= '0;
    else if (done) result_q <= final_code;
  end

  sar_irq #(.HOLD(SET_HOLD)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .kill       (arm),
    .clear      (rd_sel || start_ff),
    .intr_n     (intr_n),
    .set_active (set_active)
  );

  assign data_oe  = rd_sel;
  assign data_out = rd_sel ? result_q : '0;

endmodule

// File: rtl/sar_bus_chk.sv
module sar_bus_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cs_n,
  input logic         rd_n,
  input logic         intr_n,
  input logic         data_oe,
  input logic [W-1:0] data_out,
  input logic [W-1:0] trial_code,
  input logic         done,
  input logic         busy,
  input logic [W-1:0] ring,
  input logic         set_active,
  input logic         start_ff,
  input logic [W-1:0] result_q
);

  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  a_r3_latch_only_on_done: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(result_q));

  a_r3_bus_shows_latch: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (data_out == result_q));

  a_r4_single_step_bit: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones(ring) == 1));

  a_r4_msb_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (trial_code == MSB));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && !set_active && !done) |=> intr_n);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_active || done) |=> !intr_n);

  a_r9_arm_clears: assert property (@(posedge clk) disable iff (rst)
    (start_ff && !set_active) |=> intr_n);

endmodule

bind sar_bus_ctrl sar_bus_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .rd_n       (rd_n),
  .intr_n     (intr_n),
  .data_oe    (data_oe),
  .data_out   (data_out),
  .trial_code (trial_code),
  .done       (done),
  .busy       (busy),
  .ring       (ring),
  .set_active (set_active),
  .start_ff   (start_ff),
  .result_q   (result_q)
);

// File: tb/tb_sar_bus_ctrl.sv
module tb_sar_bus_ctrl;
  localparam int W    = 8;
  localparam int DIV  = 8;
  localparam int HOLD = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n = 1'b1;
  logic         rd_n = 1'b1;
  logic         wr_drv = 1'b1;
  logic         fr_mode = 1'b0;
  logic [W-1:0] vin = '0;
  logic         intr_n;
  logic         data_oe;
  logic [W-1:0] data_out;
  logic [W-1:0] trial_code;
  logic         cmp_ge;
  logic         wr_n;

  assign wr_n   = fr_mode ? intr_n : wr_drv;
  assign cmp_ge = (vin >= trial_code);

  always #2 clk = ~clk;

  sar_bus_ctrl #(.W(W), .DIV(DIV), .SET_HOLD(HOLD)) dut (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .cmp_ge     (cmp_ge),
    .trial_code (trial_code),
    .intr_n     (intr_n),
    .data_out   (data_out),
    .data_oe    (data_oe)
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_bus(output logic [W-1:0] v);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    v = data_out;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic start_conv();
    cs_n = 1'b0; wr_drv = 1'b0;
    @(negedge clk);
    wr_drv = 1'b1; cs_n = 1'b1;
  endtask

  task automatic convert(input logic [W-1:0] v, output int lat, output logic [W-1:0] first_trial);
    vin = v;
    start_conv();
    lat = 0;
    first_trial = '0;
    while (intr_n && lat < 200) begin
      @(negedge clk);
      lat++;
      if (first_trial == '0) first_trial = trial_code;
    end
  endtask

  task automatic wait_fall(input int limit);
    for (int i = 0; i < limit && intr_n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  initial begin
    int lat;
    int w;
    logic [W-1:0] ft;
    logic [W-1:0] rv;
    logic [W-1:0] held;
    logic [W-1:0] expv;

    // R1: state during and after reset
    step(3);
    chk(intr_n == 1'b1, "R1 intr_n in reset", intr_n, 1);
    chk(data_oe == 1'b0, "R1 data_oe in reset", data_oe, 0);
    chk(trial_code == '0, "R1 trial_code in reset", trial_code, 0);
    rst = 1'b0;
    step(1);
    read_bus(rv);
    chk(rv == '0, "R1 first read", rv, 0);

    // R2: pad enable follows select and read
    cs_n = 1'b0; rd_n = 1'b1; #1;
    chk(!data_oe && data_out == '0, "R2 cs only", data_oe, 0);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk(!data_oe && data_out == '0, "R2 rd only", data_oe, 0);
    cs_n = 1'b0; rd_n = 1'b0; #1;
    chk(data_oe == 1'b1, "R2 both low", data_oe, 1);
    cs_n = 1'b1; rd_n = 1'b1;
    step(1);

    // R3 R4 R5 R6: sweep every input code
    for (int v = 0; v < (1 << W); v++) begin
      convert(W'(v), lat, ft);
      chk(lat >= W*DIV + 1 && lat <= (W+1)*DIV, "R5 latency", lat, W*DIV + 1);
      chk(ft == 8'h80, "R4 first trial", ft, 8'h80);
      step(HOLD + 2);
      chk(intr_n == 1'b0, "R6 interrupt held until read", intr_n, 0);
      read_bus(rv);
      chk(rv == W'(v), "R3 result code", rv, v);
      chk(intr_n == 1'b1, "R6 read clears", intr_n, 1);
    end

    // R7: continuous read, interrupt low for HOLD cycles
    vin = 8'h3C;
    cs_n = 1'b0; rd_n = 1'b0;
    wr_drv = 1'b0;
    step(1);
    wr_drv = 1'b1;
    wait_fall(200);
    chk(data_out == 8'h3C, "R7 data under continuous read", data_out, 8'h3C);
    w = 0;
    while (!intr_n && w < 50) begin
      w++;
      @(negedge clk);
    end
    chk(w == HOLD, "R7 pulse width", w, HOLD);
    cs_n = 1'b1; rd_n = 1'b1;
    step(2);

    // R8: abort keeps old result, restart yields new one
    convert(8'h5A, lat, ft);
    step(HOLD + 2);
    read_bus(rv);
    chk(rv == 8'h5A, "R8 baseline", rv, 8'h5A);
    vin = 8'hC3;
    start_conv();
    step(30);
    read_bus(rv);
    chk(rv == 8'h5A, "R8 latch kept mid search", rv, 8'h5A);
    vin = 8'h21;
    start_conv();
    step(40);
    read_bus(rv);
    chk(rv == 8'h5A, "R8 latch kept after abort", rv, 8'h5A);
    wait_fall(200);
    step(HOLD + 2);
    read_bus(rv);
    chk(rv == 8'h21, "R8 restarted result", rv, 8'h21);

    // R9: arming clears a pending interrupt
    convert(8'h77, lat, ft);
    step(HOLD + 4);
    chk(intr_n == 1'b0, "R9 pending before arm", intr_n, 0);
    cs_n = 1'b0; wr_drv = 1'b0;
    step(2);
    chk(intr_n == 1'b1, "R9 cleared by arm", intr_n, 1);
    wr_drv = 1'b1; cs_n = 1'b1;
    wait_fall(200);
    step(HOLD + 2);
    read_bus(rv);
    chk(rv == 8'h77, "R9 following result", rv, 8'h77);

    // R10: free-running loop
    vin = 8'h10;
    cs_n = 1'b0;
    wr_drv = 1'b0;
    step(1);
    wr_drv = 1'b1;
    fr_mode = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wait_fall(200);
      expv = vin;
      rd_n = 1'b0; #1;
      chk(data_out == expv, "R10 free-run result", data_out, expv);
      rd_n = 1'b1;
      vin = W'(8'h10 + 37 * (k + 1));
      w = 0;
      while (!intr_n && w < 20) begin
        w++;
        @(negedge clk);
      end
      chk(w >= 1 && w <= 2, "R10 short pulse", w, 2);
    end
    fr_mode = 1'b0;
    cs_n = 1'b1;
    step(120);
    read_bus(held);
    step(2);

    // R11: writes without select are ignored
    vin = ~held;
    for (int k = 0; k < 3; k++) begin
      wr_drv = 1'b0; step(2);
      wr_drv = 1'b1; step(3);
    end
    step(100);
    chk(intr_n == 1'b1, "R11 no interrupt", intr_n, 1);
    read_bus(rv);
    chk(rv == held, "R11 latch unchanged", rv, held);

    // R12: reset mid search
    convert(8'hE0, lat, ft);
    step(HOLD + 2);
    read_bus(rv);
    vin = 8'h99;
    start_conv();
    step(40);
    rst = 1'b1;
    step(1);
    chk(intr_n == 1'b1, "R12 intr_n after reset", intr_n, 1);
    chk(trial_code == '0, "R12 trial after reset", trial_code, 0);
    rst = 1'b0;
    step(1);
    read_bus(rv);
    chk(rv == '0, "R12 latch after reset", rv, 0);
    convert(8'h42, lat, ft);
    step(HOLD + 2);
    read_bus(rv);
    chk(rv == 8'h42, "R12 next search", rv, 8'h42);

    finish_run();
  end

endmodule